// File: doc/BRIEF.md
# Accumulator Adder-Logic Unit

This block is the arithmetic slice that sits behind a 16-bit accumulator (AC) and its one-bit extension flag (E). Each cycle it looks at a set of separate operation strobes, one per operation. When exactly one strobe is high, it forms the next AC and E from the current register contents, a 16-bit data operand and an 8-bit input byte. It loads that result on the rising clock edge.

Decoding of instruction words happens upstream. The controller raises a single strobe in the cycle the operation should take effect. Three status outputs are formed combinationally from the registered AC and E. They tell skip logic whether AC is zero, whether AC is negative, and whether E is clear.

Top module: `accum_logic_unit`

## Requirements
- R1: A synchronous active-high reset clears AC and E. After reset acc_zero is 1, acc_neg is 0 and e_zero is 1.
- R2: Strobe bit 0 (AND) loads AC with the bitwise AND of AC and the data operand. E is left unchanged.
- R3: Strobe bit 1 (ADD) loads AC with AC plus the data operand, modulo 2^16. The carry out of bit 15 goes into E.
- R4: Strobe bit 2 copies the data operand into AC. E is left unchanged.
- R5: Strobe bit 3 places the input byte in AC bits 7..0 and clears AC bits 15..8. E is left unchanged.
- R6: Strobe bit 4 inverts every AC bit, and strobe bit 8 clears AC. Neither alters E.
- R7: Strobe bit 5 rotates the 17-bit ring {E, AC} right by one: AC[15] gets the old E, and E gets the old AC[0].
- R8: Strobe bit 6 rotates the ring left by one: AC[0] gets the old E, and E gets the old AC[15].
- R9: Strobe bit 7 adds one to AC, wrapping from 0xFFFF to 0x0000. E is not changed.
- R10: Strobe bit 9 clears E and strobe bit 10 inverts E. AC is unchanged by either.
- R11: With no strobe active, AC and E hold their values.
- R12: With more than one strobe active in a cycle, no operation is performed and AC and E hold.
- R13: acc_zero equals (AC == 0), acc_neg equals AC[15], and e_zero equals (E == 0). All three follow the registers in the same cycle they change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 11 | One strobe per operation, bit positions as in R2 to R10 |
| dr_in | input | 16 | Data operand |
| in_byte | input | 8 | Input byte for the low-half load |
| acc_out | output | 16 | Registered accumulator |
| e_out | output | 1 | Registered extension flag |
| acc_zero | output | 1 | High when AC is zero |
| acc_neg | output | 1 | Copy of AC bit 15 |
| e_zero | output | 1 | High when E is clear |

## Verification
The assertions cover several rules on every cycle:
- the hold rules for idle and for conflicting strobes;
- the reset state;
- that E-only operations keep AC intact;
- that ring rotations move the right bits between AC and E;
- that increment never touches E.

The arithmetic cases need the bench's scenarios, because they depend on particular operand values. These are add carry generation, increment wrap, masking by AND, clearing of the high byte on the byte load, and the status flags crossing zero and sign.

// File: rtl/acc_unit_pkg.sv
package acc_unit_pkg;
  localparam int OP_AND   = 0;
  localparam int OP_ADD   = 1;
  localparam int OP_LDDR  = 2;
  localparam int OP_LDIN  = 3;
  localparam int OP_CMP   = 4;
  localparam int OP_ROTR  = 5;
  localparam int OP_ROTL  = 6;
  localparam int OP_INCR  = 7;
  localparam int OP_CLRA  = 8;
  localparam int OP_CLRE  = 9;
  localparam int OP_CMPE  = 10;
  localparam int OP_COUNT = 11;
endpackage

// File: rtl/acc_next_calc.sv
module acc_next_calc
  import acc_unit_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IN_W   = 8
) (
  input  logic [OP_COUNT-1:0] sel,
  input  logic [DATA_W-1:0]   acc_q,
  input  logic                e_q,
  input  logic [DATA_W-1:0]   dr,
  input  logic [IN_W-1:0]     byte_in,
  output logic [DATA_W-1:0]   nxt_acc,
  output logic                nxt_e,
  output logic                upd
);
  localparam int RING_W = DATA_W + 1;

  logic [RING_W-1:0] sum_w;
  logic [RING_W-1:0] ring, ring_r, ring_l;
  logic [DATA_W-1:0] byte_ext;
  logic              single;

  generate
    if (DATA_W > IN_W) begin : g_pad
      assign byte_ext = {{(DATA_W-IN_W){1'b0}}, byte_in};
    end else begin : g_trunc
      assign byte_ext = byte_in[DATA_W-1:0];
    end
  endgenerate

  assign sum_w  = {1'b0, acc_q} + {1'b0, dr};
  assign ring   = {e_q, acc_q};
  assign ring_r = {ring[0], ring[RING_W-1:1]};
  assign ring_l = {ring[RING_W-2:0], ring[RING_W-1]};
  assign single = (sel != '0) && ((sel & (sel - 1'b1)) == '0);
  assign upd    = single;

  always_comb begin
    nxt_acc = acc_q;
    nxt_e   = e_q;
    if (single) begin
      if (sel[OP_AND])  nxt_acc = acc_q & dr;
      if (sel[OP_ADD])  {nxt_e, nxt_acc} = sum_w;
      if (sel[OP_LDDR]) nxt_acc = dr;
      if (sel[OP_LDIN]) nxt_acc = byte_ext;
      if (sel[OP_CMP])  nxt_acc = ~acc_q;
      if (sel[OP_ROTR]) {nxt_e, nxt_acc} = ring_r;
      if (sel[OP_ROTL]) {nxt_e, nxt_acc} = ring_l;
      if (sel[OP_INCR]) nxt_acc = acc_q + 1'b1;
      if (sel[OP_CLRA]) nxt_acc = '0;
      if (sel[OP_CLRE]) nxt_e = 1'b0;
      if (sel[OP_CMPE]) nxt_e = ~e_q;
    end
  end
endmodule

// File: rtl/acc_state_reg.sv
module acc_state_reg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [DATA_W-1:0] nxt_acc,
  input  logic              nxt_e,
  output logic [DATA_W-1:0] acc_q,
  output logic              e_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      e_q   <= 1'b0;
    end else if (upd) begin
      acc_q <= nxt_acc;
      e_q   <= nxt_e;
    end
  end
endmodule

// File: rtl/acc_flags.sv
module acc_flags #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc_q,
  input  logic              e_q,
  output logic              is_zero,
  output logic              is_neg,
  output logic              e_clear
);
  assign is_zero = ~|acc_q;
  assign is_neg  = acc_q[DATA_W-1];
  assign e_clear = ~e_q;
endmodule

// File: rtl/accum_logic_unit.sv
module accum_logic_unit
  import acc_unit_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int IN_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_COUNT-1:0] op_sel,
  input  logic [DATA_W-1:0]   dr_in,
  input  logic [IN_W-1:0]     in_byte,
  output logic [DATA_W-1:0]   acc_out,
  output logic                e_out,
  output logic                acc_zero,
  output logic                acc_neg,
  output logic                e_zero
);
  localparam logic [OP_COUNT-1:0] M_ROTR = OP_COUNT'(1) << OP_ROTR;
  localparam logic [OP_COUNT-1:0] M_ROTL = OP_COUNT'(1) << OP_ROTL;
  localparam logic [OP_COUNT-1:0] M_INCR = OP_COUNT'(1) << OP_INCR;
  localparam logic [OP_COUNT-1:0] M_CLRE = OP_COUNT'(1) << OP_CLRE;
  localparam logic [OP_COUNT-1:0] M_CMPE = OP_COUNT'(1) << OP_CMPE;

  logic [DATA_W-1:0] acc_q, nxt_acc;
  logic              e_q, nxt_e, upd;

  acc_next_calc #(.DATA_W(DATA_W), .IN_W(IN_W)) u_calc (
    .sel(op_sel), .acc_q(acc_q), .e_q(e_q), .dr(dr_in), .byte_in(in_byte),
    .nxt_acc(nxt_acc), .nxt_e(nxt_e), .upd(upd)
  );

  acc_state_reg #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .upd(upd), .nxt_acc(nxt_acc), .nxt_e(nxt_e),
    .acc_q(acc_q), .e_q(e_q)
  );

  acc_flags #(.DATA_W(DATA_W)) u_flags (
    .acc_q(acc_q), .e_q(e_q),
    .is_zero(acc_zero), .is_neg(acc_neg), .e_clear(e_zero)
  );

  assign acc_out = acc_q;
  assign e_out   = e_q;

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (acc_out == '0) && !e_out);

  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (op_sel == '0) |=> $stable(acc_out) && $stable(e_out));

  a_r12_conflict_hold: assert property (@(posedge clk) disable iff (rst)
    ($countones(op_sel) > 1) |=> $stable(acc_out) && $stable(e_out));

  a_r10_e_ops_keep_acc: assert property (@(posedge clk) disable iff (rst)
    (op_sel == M_CLRE || op_sel == M_CMPE) |=> $stable(acc_out));

  a_r10_clear_e: assert property (@(posedge clk) disable iff (rst)
    (op_sel == M_CLRE) |=> !e_out);

  a_r9_inc_keeps_e: assert property (@(posedge clk) disable iff (rst)
    (op_sel == M_INCR) |=> $stable(e_out));

  a_r7_rotr_ring: assert property (@(posedge clk) disable iff (rst)
    (op_sel == M_ROTR) |=> (e_out == $past(acc_out[0])) &&
                           (acc_out[DATA_W-1] == $past(e_out)));

  a_r8_rotl_ring: assert property (@(posedge clk) disable iff (rst)
    (op_sel == M_ROTL) |=> (e_out == $past(acc_out[DATA_W-1])) &&
                           (acc_out[0] == $past(e_out)));
endmodule

// File: tb/accum_logic_unit_bench.sv
module accum_logic_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NOPS = 11;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [NOPS-1:0] op_sel = '0;
  logic [15:0] dr_in = '0;
  logic [7:0]  in_byte = '0;
  logic [15:0] acc_out;
  logic        e_out, acc_zero, acc_neg, e_zero;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  accum_logic_unit u_accum_logic_unit (
    .clk(clk), .rst(rst), .op_sel(op_sel), .dr_in(dr_in), .in_byte(in_byte),
    .acc_out(acc_out), .e_out(e_out), .acc_zero(acc_zero),
    .acc_neg(acc_neg), .e_zero(e_zero)
  );

  task automatic check(input string req, input logic [15:0] exp_a, input logic exp_e);
    n_chk++;
    if (acc_out !== exp_a || e_out !== exp_e) begin
      n_bad++;
      $display("FAIL %s: acc=%h e=%b expected acc=%h e=%b", req, acc_out, e_out, exp_a, exp_e);
    end
  endtask

  task automatic check_flags(input string req);
    logic [2:0] exp_f, got_f;
    exp_f = {acc_out == 16'h0, acc_out[15], e_out == 1'b0};
    got_f = {acc_zero, acc_neg, e_zero};
    n_chk++;
    if (got_f !== exp_f) begin
      n_bad++;
      $display("FAIL %s: flags=%b expected %b", req, got_f, exp_f);
    end
  endtask

  task automatic do_op(input logic [NOPS-1:0] s, input logic [15:0] d, input logic [7:0] b);
    @(negedge clk);
    op_sel = s; dr_in = d; in_byte = b;
    @(negedge clk);
    op_sel = '0;
  endtask

  function automatic logic [NOPS-1:0] bit_of(input int i);
    return NOPS'(1) << i;
  endfunction

  task automatic set_state(input logic [15:0] a, input logic e);
    do_op(bit_of(2), a, 8'h00);
    do_op(bit_of(9), 16'h0, 8'h00);
    if (e) do_op(bit_of(10), 16'h0, 8'h00);
  endtask

  task automatic t_reset;
    check("R1", 16'h0000, 1'b0);
    n_chk++;
    if ({acc_zero, acc_neg, e_zero} !== 3'b101) begin
      n_bad++;
      $display("FAIL R1: flags=%b expected 101", {acc_zero, acc_neg, e_zero});
    end
  endtask

  task automatic t_and;
    set_state(16'hF0F0, 1'b1);
    do_op(bit_of(0), 16'h3C3C, 8'h00);
    check("R2", 16'h3030, 1'b1);
  endtask

  task automatic t_add;
    set_state(16'hFFFF, 1'b0);
    do_op(bit_of(1), 16'h0001, 8'h00);
    check("R3 carry", 16'h0000, 1'b1);
    check_flags("R13 zero after add");
    do_op(bit_of(1), 16'h1234, 8'h00);
    check("R3 no carry", 16'h1234, 1'b0);
    do_op(bit_of(1), 16'h8000, 8'h00);
    check("R3 sum", 16'h9234, 1'b0);
    check_flags("R13 negative");
  endtask

  task automatic t_loads;
    set_state(16'h0000, 1'b1);
    do_op(bit_of(2), 16'hABCD, 8'h00);
    check("R4", 16'hABCD, 1'b1);
    do_op(bit_of(3), 16'hFFFF, 8'h5A);
    check("R5", 16'h005A, 1'b1);
  endtask

  task automatic t_cmp_clr;
    set_state(16'h005A, 1'b0);
    do_op(bit_of(4), 16'h0000, 8'h00);
    check("R6 complement", 16'hFFA5, 1'b0);
    check_flags("R13 after complement");
    do_op(bit_of(8), 16'h1111, 8'h00);
    check("R6 clear", 16'h0000, 1'b0);
  endtask

  task automatic t_rotr;
    set_state(16'h0001, 1'b0);
    do_op(bit_of(5), 16'h0, 8'h0);
    check("R7 step1", 16'h0000, 1'b1);
    do_op(bit_of(5), 16'h0, 8'h0);
    check("R7 step2", 16'h8000, 1'b0);
    do_op(bit_of(5), 16'h0, 8'h0);
    check("R7 step3", 16'h4000, 1'b0);
  endtask

  task automatic t_rotl;
    set_state(16'h8000, 1'b0);
    do_op(bit_of(6), 16'h0, 8'h0);
    check("R8 step1", 16'h0000, 1'b1);
    do_op(bit_of(6), 16'h0, 8'h0);
    check("R8 step2", 16'h0001, 1'b0);
  endtask

  task automatic t_inc;
    set_state(16'hFFFF, 1'b0);
    do_op(bit_of(7), 16'h0, 8'h0);
    check("R9 wrap", 16'h0000, 1'b0);
    set_state(16'h0004, 1'b1);
    do_op(bit_of(7), 16'h0, 8'h0);
    check("R9 keep E", 16'h0005, 1'b1);
  endtask

  task automatic t_eops;
    set_state(16'h7E81, 1'b1);
    do_op(bit_of(9), 16'h0, 8'h0);
    check("R10 clear E", 16'h7E81, 1'b0);
    check_flags("R13 e clear");
    do_op(bit_of(10), 16'h0, 8'h0);
    check("R10 complement E", 16'h7E81, 1'b1);
  endtask

  task automatic t_hold;
    set_state(16'h2468, 1'b1);
    do_op('0, 16'hFFFF, 8'hFF);
    @(negedge clk);
    check("R11 idle", 16'h2468, 1'b1);
    do_op(bit_of(1) | bit_of(4), 16'hFFFF, 8'h00);
    check("R12 two strobes", 16'h2468, 1'b1);
    do_op(bit_of(3) | bit_of(8) | bit_of(9), 16'h0, 8'h77);
    check("R12 three strobes", 16'h2468, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_and();
    t_add();
    t_loads();
    t_cmp_clr();
    t_rotr();
    t_rotl();
    t_inc();
    t_eops();
    t_hold();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule